// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block is the interrupt logic of a 16550-style serial port. It keeps a writable interrupt-enable register and tracks five interrupt sources: receive errors, received data, receiver timeout, transmitter data request and modem-status change. From these it forms a read-only identification value and a single interrupt line. The identification value shows whether any enabled source is pending and, if so, which one ranks highest among four priority levels. Software reads it to decide which service routine to run. Reading the identification value, the line-status register or the modem-status register clears the matching sticky source.

The enable register can be reached on the register bus only while the divisor-latch access bit is 0. It holds the usual per-source enables, a separate receiver-timeout enable and a master enable for the whole unit. Two further bits are plain storage and affect nothing.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, no source is pending, `irq` is 0 and `irq_id` is 4'b0001.
- R2: With `dlab`=0, a write at address 1 stores `bus_wdata` into the enable register, and a read at address 1 returns it on `bus_rdata`. With `dlab`=1, a write at address 1 leaves the register unchanged and a read at address 1 returns 0.
- R3: Enable bits 7 and 5 are stored and read back, but they never change `irq` or `irq_id`.
- R4: While enable bit 6 (unit enable) is 0, `irq` is 0 and `irq_id` is 4'b0001, whatever the sources are.
- R5: `irq_id` has bit 0 = 0 when an enabled source is pending, and bits 3:1 carry that source's code. The codes are: line status 3'b011 (level 1, highest); data available 3'b010 and timeout 3'b110 (both level 2, with data available first); transmit request 3'b001 (level 3); modem status 3'b000 (level 4). With nothing pending, `irq_id` is 4'b0001. A read at address 2 returns `irq_id` in bits 3:0 of `bus_rdata`, with the upper bits 0.
- R6: The data-available source follows `rx_trig_hit` when `fifo_mode`=1 and `rbr_full` when `fifo_mode`=0, delayed by one clock.
- R7: A pulse on `line_err_set` makes line status pending, and it stays pending until a `lsr_read` pulse. A set in the same cycle as a read wins.
- R8: A pulse on `modem_chg` makes modem status pending, and it stays pending until a `msr_read` pulse.
- R9: A pulse on `tx_req_set` makes the transmit request pending. It clears only on a read at address 2 made while `irq_id` shows the transmit code. A read at address 2 that shows any other code leaves it pending.
- R10: `irq` is the OR of all sources that are both pending and enabled, gated by unit enable. Enable bit mapping: 0 data available, 1 transmit request, 2 line status, 3 modem, 4 timeout. It changes one clock after a status input changes.
- R11: A pending source whose enable bit is 0 never shows in `irq_id`; the highest enabled pending source is reported instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| dlab | input | 1 | Divisor-latch access bit from line control |
| fifo_mode | input | 1 | 1 when the receive FIFO is in use |
| line_err_set | input | 1 | Pulse: a receive error bit was set |
| lsr_read | input | 1 | Pulse: line-status register was read |
| rx_trig_hit | input | 1 | Level: receive FIFO at trigger level |
| rbr_full | input | 1 | Level: receive buffer holds a character |
| rx_timeout | input | 1 | Level: receiver timeout condition |
| tx_req_set | input | 1 | Pulse: transmitter requests data |
| modem_chg | input | 1 | Pulse: modem-status inputs changed |
| msr_read | input | 1 | Pulse: modem-status register was read |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Identification value: code in bits 3:1, bit 0 = no interrupt |

## Verification
Source state is registered, so `irq` and `irq_id` change one clock after a status input or an enable write. Bus reads return data in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge, which is one rising edge later and matches that one-register latency. Same-cycle read data is sampled shortly after the read strobe is driven, and the clear caused by a read is checked one falling edge later. The test sweeps every combination of pending sources against every setting of the unit and source enables, and compares the results with a priority-table model kept in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int SRC_N = 5;

  // source index == enable bit position
  localparam int S_RXDATA = 0;
  localparam int S_TXREQ  = 1;
  localparam int S_LINE   = 2;
  localparam int S_MODEM  = 3;
  localparam int S_TMO    = 4;
  localparam int EN_UNIT  = 6;

  typedef enum logic [2:0] {
    ID_MODEM  = 3'b000,
    ID_TXREQ  = 3'b001,
    ID_RXDATA = 3'b010,
    ID_LINE   = 3'b011,
    ID_TMO    = 3'b110
  } irq_code_e;

  localparam logic [3:0] ID_NONE = 4'b0001;

  // Identification value from the enabled, pending source vector.
  function automatic logic [3:0] ident_value(input logic [SRC_N-1:0] act);
    logic [3:0] v;
    if (act[S_LINE])        v = {ID_LINE, 1'b0};
    else if (act[S_RXDATA]) v = {ID_RXDATA, 1'b0};
    else if (act[S_TMO])    v = {ID_TMO, 1'b0};
    else if (act[S_TXREQ])  v = {ID_TXREQ, 1'b0};
    else if (act[S_MODEM])  v = {ID_MODEM, 1'b0};
    else                    v = ID_NONE;
    return v;
  endfunction

endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int ADDR_IER = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dlab,
  output logic [DATA_W-1:0] en_q,
  output logic              wr_hit
);

  assign wr_hit = wr && !dlab && (addr == ADDR_W'(ADDR_IER));

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wdata;
  end

  // R2
  dlab_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dlab) |=> $stable(en_q));

endmodule

// File: rtl/irq_src_track.sv
module irq_src_track
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             line_err_set,
  input  logic             lsr_read,
  input  logic             rx_trig_hit,
  input  logic             rbr_full,
  input  logic             rx_timeout,
  input  logic             tx_req_set,
  input  logic             tx_clr,
  input  logic             modem_chg,
  input  logic             msr_read,
  output logic [SRC_N-1:0] pend
);

  logic line_q, modem_q, tx_q, rxd_q, tmo_q;
  logic rxd_src;

  assign rxd_src = fifo_mode ? rx_trig_hit : rbr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      modem_q <= 1'b0;
      tx_q    <= 1'b0;
      rxd_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      line_q  <= line_err_set | (line_q & ~lsr_read);
      modem_q <= modem_chg    | (modem_q & ~msr_read);
      tx_q    <= tx_req_set   | (tx_q & ~tx_clr);
      rxd_q   <= rxd_src;
      tmo_q   <= rx_timeout;
    end
  end

  always_comb begin
    pend           = '0;
    pend[S_RXDATA] = rxd_q;
    pend[S_TXREQ]  = tx_q;
    pend[S_LINE]   = line_q;
    pend[S_MODEM]  = modem_q;
    pend[S_TMO]    = tmo_q;
  end

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !lsr_read) |=> line_q);
  // R8
  modem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_q && !msr_read) |=> modem_q);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q && !tx_clr) |=> tx_q);

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import uart_irq_pkg::*;
(
  input  logic [SRC_N-1:0] act,
  output logic [3:0]       id,
  output logic [SRC_N-1:0] grant
);

  // rank order, highest first
  localparam int ORDER [SRC_N] = '{S_LINE, S_RXDATA, S_TMO, S_TXREQ, S_MODEM};

  logic [SRC_N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar k = 0; k < SRC_N; k++) begin : g_rank
    assign grant[ORDER[k]] = act[ORDER[k]] && !blocked[k];
    assign blocked[k+1]    = blocked[k] || act[ORDER[k]];
  end

  assign id = ident_value(act);

  // R5
  single_grant_chk: assert final ($onehot0(grant));
  // R5
  pending_flag_chk: assert final ((|grant) == !id[0]);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int ADDR_IER = 1,
  parameter int ADDR_IIR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dlab,
  input  logic              fifo_mode,
  input  logic              line_err_set,
  input  logic              lsr_read,
  input  logic              rx_trig_hit,
  input  logic              rbr_full,
  input  logic              rx_timeout,
  input  logic              tx_req_set,
  input  logic              modem_chg,
  input  logic              msr_read,
  output logic              irq,
  output logic [3:0]        irq_id
);

  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(ADDR_IER);
  localparam logic [ADDR_W-1:0] A_IIR = ADDR_W'(ADDR_IIR);

  logic [DATA_W-1:0] en_q;
  logic              en_wr_hit;
  logic [SRC_N-1:0]  pend;
  logic [SRC_N-1:0]  act;
  logic [SRC_N-1:0]  grant;
  logic              unit_on;
  logic              iir_rd;
  logic              tx_clr;

  irq_en_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_IER(ADDR_IER)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dlab(dlab), .en_q(en_q), .wr_hit(en_wr_hit)
  );

  assign unit_on = en_q[EN_UNIT];
  assign iir_rd  = bus_rd && (bus_addr == A_IIR);
  assign tx_clr  = iir_rd && grant[S_TXREQ];

  irq_src_track u_src (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .line_err_set(line_err_set), .lsr_read(lsr_read),
    .rx_trig_hit(rx_trig_hit), .rbr_full(rbr_full), .rx_timeout(rx_timeout),
    .tx_req_set(tx_req_set), .tx_clr(tx_clr),
    .modem_chg(modem_chg), .msr_read(msr_read), .pend(pend)
  );

  for (genvar s = 0; s < SRC_N; s++) begin : g_mask
    assign act[s] = pend[s] && en_q[s] && unit_on;
  end

  irq_prio_encoder u_prio (.act(act), .id(irq_id), .grant(grant));

  assign irq = |act;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_IER && !dlab) bus_rdata = en_q;
    else if (bus_addr == A_IIR)     bus_rdata = DATA_W'(irq_id);
  end

  // R4
  unit_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_on |-> (!irq && irq_id == ID_NONE));
  // R10
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !irq_id[0]);
  // R9
  tx_clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !tx_req_set) |=> !pend[S_TXREQ]);
  // R2
  en_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_hit |=> (en_q == $past(bus_wdata)));

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic dlab = 0, fifo_mode = 0;
  logic line_err_set = 0, lsr_read = 0, rx_trig_hit = 0, rbr_full = 0;
  logic rx_timeout = 0, tx_req_set = 0, modem_chg = 0, msr_read = 0;
  logic irq;
  logic [3:0] irq_id;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_dut (.*);

  // bench model: priority table, source index == enable bit
  function automatic logic [3:0] model_id(input logic [4:0] p, input logic [7:0] en);
    int idx [5] = '{2, 0, 4, 1, 3};
    logic [2:0] code [5] = '{3'b011, 3'b010, 3'b110, 3'b001, 3'b000};
    if (!en[6]) return 4'b0001;
    for (int k = 0; k < 5; k++)
      if (p[idx[k]] && en[idx[k]]) return {code[k], 1'b0};
    return 4'b0001;
  endfunction

  function automatic logic model_irq(input logic [4:0] p, input logic [7:0] en);
    return en[6] && |(p & en[4:0]);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    #2 d = bus_rdata;
    step();
    bus_rd = 0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rx_trig_hit = 0; rbr_full = 0; rx_timeout = 0;
    lsr_read = 1; msr_read = 1;
    step();
    lsr_read = 0; msr_read = 0;
    wr_reg(3'd1, 8'h42);
    rd_reg(3'd2, d);
    step();
    chk("R9 clear", {7'd0, irq}, 8'd0);
  endtask

  task automatic set_pattern(input logic [4:0] p, input logic fm);
    fifo_mode   = fm;
    rx_trig_hit = fm ? p[0] : ~p[0];
    rbr_full    = fm ? ~p[0] : p[0];
    rx_timeout  = p[4];
    line_err_set = p[2]; tx_req_set = p[1]; modem_chg = p[3];
    step();
    line_err_set = 0; tx_req_set = 0; modem_chg = 0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    step(); step();
    rst_n = 1;
    step();
    // R1
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 id", {4'd0, irq_id}, 8'h01);
    rd_reg(3'd1, d);
    chk("R1 ier", d, 8'h00);

    // R2 write/read with dlab low, ignored with dlab high
    wr_reg(3'd1, 8'hA5);
    rd_reg(3'd1, d);
    chk("R2 readback", d, 8'hA5);
    dlab = 1;
    wr_reg(3'd1, 8'h5A);
    rd_reg(3'd1, d);
    chk("R2 dlab read", d, 8'h00);
    dlab = 0;
    rd_reg(3'd1, d);
    chk("R2 dlab write ignored", d, 8'hA5);

    // R10 timing: one clock after the strobe
    clear_all();
    wr_reg(3'd1, 8'h42);
    tx_req_set = 1;
    #2 chk("R10 not early", {7'd0, irq}, 8'd0);
    step();
    tx_req_set = 0;
    chk("R10 one clock", {7'd0, irq}, 8'd1);

    // R9 read showing a higher code keeps tx pending
    line_err_set = 1; step(); line_err_set = 0;
    wr_reg(3'd1, 8'h46);
    rd_reg(3'd2, d);
    chk("R5 iir read line", d, 8'h06);
    lsr_read = 1; step(); lsr_read = 0;
    chk("R9 tx kept", {4'd0, irq_id}, 8'h02);
    rd_reg(3'd2, d);
    chk("R9 read shows tx", d, 8'h02);
    chk("R9 tx cleared", {4'd0, irq_id}, 8'h01);

    // R7 set wins over read in same cycle
    line_err_set = 1; lsr_read = 1; step();
    line_err_set = 0; lsr_read = 0;
    chk("R7 set wins", {4'd0, irq_id}, 8'h06);
    lsr_read = 1; step(); lsr_read = 0;
    chk("R7 cleared", {4'd0, irq_id}, 8'h01);

    // R8 modem hold then clear
    wr_reg(3'd1, 8'h48);
    modem_chg = 1; step(); modem_chg = 0;
    step();
    chk("R8 held", {4'd0, irq_id}, 8'h00);
    msr_read = 1; step(); msr_read = 0;
    chk("R8 cleared", {4'd0, irq_id}, 8'h01);

    // sweep: R3 R4 R5 R6 R10 R11
    for (int p = 0; p < 32; p++) begin
      for (int fm = 0; fm < 2; fm++) begin
        clear_all();
        set_pattern(5'(p), fm[0]);
        for (int e = 0; e < 128; e++) begin
          logic [7:0] en;
          en = {1'b0, e[6], 1'b0, e[4:0]};
          if (e[5]) en = en | 8'hA0;  // R3 storage-only bits
          wr_reg(3'd1, en);
          chk("R5 R6 R11 id", {4'd0, irq_id}, {4'd0, model_id(5'(p), en)});
          chk("R4 R10 irq", {7'd0, irq}, {7'd0, model_irq(5'(p), en)});
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule